// File: doc/BRIEF.md
# Double-Precision Special-Case Fixup Lane

This block repairs one IEEE-754 double-precision result whose special cases were not handled by the arithmetic that produced it. Typical use: a reciprocal or root estimate, refined by a few Newton steps, is the destination operand. The original input to that computation is the source operand. A 32-bit response table then decides, for each kind of source value, whether the refined result stands or is replaced by a well-defined value.

The source first has its denormals flushed to signed zero when the flush control is high. From then on only the flushed value is used. The value is then sorted into one of eight token classes. The 4-bit action code for that class is read from the response table, and one of sixteen responses is produced. An 8-bit exception control chooses which token classes raise the invalid or divide-by-zero flags. A signalling NaN always raises invalid.

One lane is built, and wider datapaths replicate it. Inputs are captured on a valid strobe, and the result and flags appear together one clock later.

Top module: `fp_fixup_lane`

## Requirements
- R1: When `in_valid` is high at a rising edge, `out_valid` is high after that edge, and `fix_res`, `flag_inv` and `flag_dz` carry the result for those inputs. When `in_valid` is low at an edge, `out_valid` and both flags are low after it, and `fix_res` holds its previous value.
- R2: While `rst_n` is low, `out_valid`, `fix_res`, `flag_inv` and `flag_dz` are all zero.
- R3: When `daz` is high, a denormal source (exponent 0, mantissa non-zero) becomes a zero with the same sign before classification and output. When `daz` is low, a denormal is classified by its sign as a negative or positive value and passed unchanged.
- R4: Classification uses this priority: NaN first (quiet if mantissa bit 51 is set, else signalling), then infinity by sign, then zero of either sign, then the exact pattern 0x3FF0000000000000. Anything left is split by sign. Token indices are: quiet NaN 0, signalling NaN 1, zero 2, +1.0 3, -Inf 4, +Inf 5, negative 6, positive 7. The value -1.0 and values one ulp away from +1.0 are ordinary values.
- R5: The action code for token i is `tbl_in[4i+3:4i]`. Bits 63:32 of `tbl_in` have no effect.
- R6: Action code 0 outputs `dst_in` unchanged. Code 1 outputs the source after any flush.
- R7: Code 2 outputs the source NaN with bit 51 set, or the default NaN 0xFFF8000000000000 if the source is not a NaN. Code 3 always outputs 0xFFF8000000000000.
- R8: Codes 4 to 15 output these values: -Inf 0xFFF0000000000000; +Inf 0x7FF0000000000000; infinity with the source's sign; -0 0x8000000000000000; +0; -1.0 0xBFF0000000000000; +1.0 0x3FF0000000000000; 0.5 0x3FE0000000000000; 90.0 0x4056800000000000; pi/2 0x3FF921FB54442D18; +MAX 0x7FEFFFFFFFFFFFFF; -MAX 0xFFEFFFFFFFFFFFFF.
- R9: Each `exc_ctl` bit enables one flag for one token. Bit 0 gives divide-by-zero on zero. Bit 1 gives invalid on zero. Bit 2 gives invalid on negative. Bit 3 gives invalid on positive. Bit 4 gives invalid on -Inf. Bit 5 gives invalid on +1.0. Bit 6 gives divide-by-zero on +1.0. Bit 7 gives invalid on +Inf. A quiet NaN never raises a flag.
- R10: A signalling NaN source raises `flag_inv` whatever `exc_ctl` holds. With `exc_ctl` zero and a non-signalling source, both flags stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Inputs are presented this cycle |
| dst_in | input | 64 | Result to be fixed up |
| src_in | input | 64 | Operand that is classified |
| tbl_in | input | 64 | Response table (low 32 bits used) |
| exc_ctl | input | 8 | Exception enable per token |
| daz | input | 1 | Flush denormal source to zero |
| out_valid | output | 1 | Result and flags valid |
| fix_res | output | 64 | Fixed-up value |
| flag_inv | output | 1 | Invalid-operation flag |
| flag_dz | output | 1 | Divide-by-zero flag |

## Verification
Every result is due exactly one rising edge after the edge that sees `in_valid` high. The value, both flags and `out_valid` change together, because each passes through a single register. The bench drives inputs on a falling edge and reads all four outputs on the next falling edge. Each comparison therefore sits half a period after the capturing edge. Idle cycles and reset are checked the same way: the cleared state is read on the falling edge after the edge that applied it.

// File: rtl/fp_fixup_lane.sv
module fp_fixup_lane #(
  parameter int W = 64,
  parameter int TOKS = 8,
  parameter int CW = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] dst_in,
  input  logic [W-1:0] src_in,
  input  logic [W-1:0] tbl_in,
  input  logic [7:0]   exc_ctl,
  input  logic         daz,
  output logic         out_valid,
  output logic [W-1:0] fix_res,
  output logic         flag_inv,
  output logic         flag_dz
);
  localparam int EW = 11;
  localparam int MW = W - EW - 1;
  localparam int TW = $clog2(TOKS);
  localparam logic [W-1:0] QNAN_DEF = 64'hFFF8_0000_0000_0000;
  localparam logic [W-1:0] INF_POS  = 64'h7FF0_0000_0000_0000;
  localparam logic [W-1:0] ONE_POS  = 64'h3FF0_0000_0000_0000;

  logic          sgn;
  logic [EW-1:0] expo;
  logic [MW-1:0] man;
  logic          denorm;
  logic [W-1:0]  tsrc;
  logic          t_nan, t_inf, t_zero;
  logic [TW-1:0] tok;
  logic [CW-1:0] act;
  logic [W-1:0]  nxt;
  logic          nxt_inv, nxt_dz;

  assign sgn    = src_in[W-1];
  assign expo   = src_in[W-2:MW];
  assign man    = src_in[MW-1:0];
  assign denorm = (expo == '0) && (man != '0);
  assign tsrc   = (daz && denorm) ? {sgn, {(W-1){1'b0}}} : src_in;

  assign t_nan  = (tsrc[W-2:MW] == '1) && (tsrc[MW-1:0] != '0);
  assign t_inf  = (tsrc[W-2:MW] == '1) && (tsrc[MW-1:0] == '0);
  assign t_zero = (tsrc[W-2:0] == '0);

  always_comb begin
    if (t_nan)                tok = tsrc[MW-1] ? TW'(0) : TW'(1);
    else if (t_inf)           tok = tsrc[W-1] ? TW'(4) : TW'(5);
    else if (t_zero)          tok = TW'(2);
    else if (tsrc == ONE_POS) tok = TW'(3);
    else                      tok = tsrc[W-1] ? TW'(6) : TW'(7);
  end

  assign act = tbl_in[tok*CW +: CW];

  always_comb begin
    case (act)
      4'd0:  nxt = dst_in;
      4'd1:  nxt = tsrc;
      4'd2:  nxt = t_nan ? (tsrc | (64'd1 << (MW-1))) : QNAN_DEF;
      4'd3:  nxt = QNAN_DEF;
      4'd4:  nxt = {1'b1, INF_POS[W-2:0]};
      4'd5:  nxt = INF_POS;
      4'd6:  nxt = {tsrc[W-1], INF_POS[W-2:0]};
      4'd7:  nxt = {1'b1, {(W-1){1'b0}}};
      4'd8:  nxt = '0;
      4'd9:  nxt = {1'b1, ONE_POS[W-2:0]};
      4'd10: nxt = ONE_POS;
      4'd11: nxt = 64'h3FE0_0000_0000_0000;
      4'd12: nxt = 64'h4056_8000_0000_0000;
      4'd13: nxt = 64'h3FF9_21FB_5444_2D18;
      4'd14: nxt = 64'h7FEF_FFFF_FFFF_FFFF;
      default: nxt = 64'hFFEF_FFFF_FFFF_FFFF;
    endcase
  end

  assign nxt_dz  = (tok == TW'(2) && exc_ctl[0]) || (tok == TW'(3) && exc_ctl[6]);
  assign nxt_inv = (tok == TW'(1))
                || (tok == TW'(2) && exc_ctl[1])
                || (tok == TW'(6) && exc_ctl[2])
                || (tok == TW'(7) && exc_ctl[3])
                || (tok == TW'(4) && exc_ctl[4])
                || (tok == TW'(3) && exc_ctl[5])
                || (tok == TW'(5) && exc_ctl[7]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      fix_res   <= '0;
      flag_inv  <= 1'b0;
      flag_dz   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      flag_inv  <= in_valid && nxt_inv;
      flag_dz   <= in_valid && nxt_dz;
      if (in_valid) fix_res <= nxt;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && !flag_inv && !flag_dz); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(fix_res)); // R1
  AST_DAZ_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && daz && denorm && act == 4'd1 |=> fix_res[W-2:0] == '0); // R3
  AST_KEEP_DST: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && act == 4'd0 |=> fix_res == $past(dst_in)); // R6
  AST_SNAN_INV: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (src_in[W-2:MW] == '1) && !src_in[MW-1] && (src_in[MW-2:0] != '0) |=> flag_inv); // R10
  AST_CTL_OFF_NO_DZ: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && exc_ctl == 8'h00 |=> !flag_dz); // R10
endmodule

// File: tb/fp_fixup_lane_test.sv
module fp_fixup_lane_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] dst_in = '0, src_in = '0, tbl_in = '0;
  logic [7:0]  exc_ctl = '0;
  logic        daz = 1'b0;
  logic        out_valid, flag_inv, flag_dz;
  logic [63:0] fix_res;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  fp_fixup_lane uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dst_in(dst_in),
    .src_in(src_in), .tbl_in(tbl_in), .exc_ctl(exc_ctl), .daz(daz),
    .out_valid(out_valid), .fix_res(fix_res), .flag_inv(flag_inv), .flag_dz(flag_dz));

  localparam logic [63:0] DV = 64'h1234_5678_9ABC_DEF0;
  typedef struct packed {
    logic [63:0] src; logic [63:0] tbl; logic [7:0] ctl; logic dz_en;
    logic [63:0] res; logic inv; logic dz; logic [23:0] tag;
  } vec_t;
  localparam int NV = 32;
  localparam vec_t VECS [NV] = '{
    '{64'h7FF8000000000001, 64'h76543210, 8'h00, 1'b0, DV,                    1'b0, 1'b0, "R6"},
    '{64'h7FF0000000000001, 64'h76543210, 8'h00, 1'b0, 64'h7FF0000000000001, 1'b1, 1'b0, "R10"},
    '{64'h0000000000000000, 64'h76543210, 8'h00, 1'b0, 64'hFFF8000000000000, 1'b0, 1'b0, "R7"},
    '{64'h3FF0000000000000, 64'h76543210, 8'h00, 1'b0, 64'hFFF8000000000000, 1'b0, 1'b0, "R4"},
    '{64'hFFF0000000000000, 64'h76543210, 8'h00, 1'b0, 64'hFFF0000000000000, 1'b0, 1'b0, "R8"},
    '{64'h7FF0000000000000, 64'h76543210, 8'h00, 1'b0, 64'h7FF0000000000000, 1'b0, 1'b0, "R8"},
    '{64'hBFF0000000000000, 64'h76543210, 8'h00, 1'b0, 64'hFFF0000000000000, 1'b0, 1'b0, "R4"},
    '{64'h4000000000000000, 64'h76543210, 8'h00, 1'b0, 64'h8000000000000000, 1'b0, 1'b0, "R5"},
    '{64'h7FF8000000000001, 64'hFEDCBA98, 8'h00, 1'b0, 64'h0000000000000000, 1'b0, 1'b0, "R8"},
    '{64'hFFF4000000000000, 64'hFEDCBA98, 8'h00, 1'b0, 64'hBFF0000000000000, 1'b1, 1'b0, "R8"},
    '{64'h8000000000000000, 64'hFEDCBA98, 8'h00, 1'b0, 64'h3FF0000000000000, 1'b0, 1'b0, "R4"},
    '{64'h3FF0000000000000, 64'hFEDCBA98, 8'h00, 1'b0, 64'h3FE0000000000000, 1'b0, 1'b0, "R8"},
    '{64'hFFF0000000000000, 64'hFEDCBA98, 8'h00, 1'b0, 64'h4056800000000000, 1'b0, 1'b0, "R8"},
    '{64'h7FF0000000000000, 64'hFEDCBA98, 8'h00, 1'b0, 64'h3FF921FB54442D18, 1'b0, 1'b0, "R8"},
    '{64'hC000000000000000, 64'hFEDCBA98, 8'h00, 1'b0, 64'h7FEFFFFFFFFFFFFF, 1'b0, 1'b0, "R8"},
    '{64'h3FF0000000000001, 64'hFEDCBA98, 8'h00, 1'b0, 64'hFFEFFFFFFFFFFFFF, 1'b0, 1'b0, "R4"},
    '{64'h7FF0000000000001, 64'h22222222, 8'h00, 1'b0, 64'h7FF8000000000001, 1'b1, 1'b0, "R7"},
    '{64'h8000000000000001, 64'h11111111, 8'h01, 1'b1, 64'h8000000000000000, 1'b0, 1'b1, "R3"},
    '{64'h8000000000000001, 64'h11111111, 8'h05, 1'b0, 64'h8000000000000001, 1'b1, 1'b0, "R3"},
    '{64'h4000000000000000, 64'hFFFFFFFF00000000, 8'h00, 1'b0, DV,           1'b0, 1'b0, "R5"},
    '{64'h0000000000000000, 64'h00000000, 8'hFF, 1'b0, DV,                    1'b1, 1'b1, "R9"},
    '{64'h3FF0000000000000, 64'h00000000, 8'hFF, 1'b0, DV,                    1'b1, 1'b1, "R9"},
    '{64'h7FF0000000000000, 64'h00000000, 8'h80, 1'b0, DV,                    1'b1, 1'b0, "R9"},
    '{64'hFFF0000000000000, 64'h00000000, 8'h10, 1'b0, DV,                    1'b1, 1'b0, "R9"},
    '{64'h4000000000000000, 64'h00000000, 8'h08, 1'b0, DV,                    1'b1, 1'b0, "R9"},
    '{64'h4000000000000000, 64'h00000000, 8'hF7, 1'b0, DV,                    1'b0, 1'b0, "R9"},
    '{64'hC000000000000000, 64'h00000000, 8'h04, 1'b0, DV,                    1'b1, 1'b0, "R9"},
    '{64'h7FF8000000000000, 64'h00000000, 8'hFF, 1'b0, DV,                    1'b0, 1'b0, "R9"},
    '{64'h7FF0000000000001, 64'h00000000, 8'h00, 1'b0, DV,                    1'b1, 1'b0, "R10"},
    '{64'h0000000000000000, 64'h00000000, 8'h00, 1'b0, DV,                    1'b0, 1'b0, "R10"},
    '{64'h4000000000000000, 64'h88888888, 8'h00, 1'b0, 64'h0000000000000000, 1'b0, 1'b0, "R8"},
    '{64'h0000000000000005, 64'h11111111, 8'h08, 1'b0, 64'h0000000000000005, 1'b1, 1'b0, "R3"}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    in_valid = 1'b1; dst_in = DV; src_in = v.src; tbl_in = v.tbl; exc_ctl = v.ctl; daz = v.dz_en;
    @(negedge clk);
    in_valid = 1'b0;
    chk($sformatf("%s res", v.tag), fix_res, v.res);
    chk($sformatf("%s flags", v.tag), {62'd0, flag_inv, flag_dz}, {62'd0, v.inv, v.dz});
    chk($sformatf("%s valid", v.tag), {63'd0, out_valid}, 64'd1);
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R2 reset res", fix_res, 64'd0);
    chk("R2 reset ctl", {61'd0, out_valid, flag_inv, flag_dz}, 64'd0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) apply(VECS[i]);
    // R1: idle cycle with a signalling NaN on the source
    src_in = 64'h7FF0000000000001; exc_ctl = 8'hFF;
    @(negedge clk);
    chk("R1 idle flags", {61'd0, out_valid, flag_inv, flag_dz}, 64'd0);
    chk("R1 idle hold", fix_res, 64'h0000000000000005);
    // R2: reset after activity
    apply(VECS[1]);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R2 rerun res", fix_res, 64'd0);
    chk("R2 rerun ctl", {61'd0, out_valid, flag_inv, flag_dz}, 64'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule